// File: doc/BRIEF.md
# Multi-Master Serial Clock Generator

This block produces the serial clock of a two-wire bus master on an open-drain clock line. It counts a programmed low phase and a programmed high phase, with one pair of counts for 100 kHz standard mode and another for 400 kHz fast mode. It pulls the line low only during its own low phase. At all other times it releases the line and watches the real level through a two-flop synchroniser.

The real level drives two behaviours. If a slave or another master holds the line low after the local low count has ended, the high phase does not begin until the line is seen high. If anyone pulls the line low during the local high phase, the high phase ends at once and a fresh low count starts from zero. As a result, the wired-AND line carries the longest low phase and the shortest high phase of all participants.

One-cycle strobes mark each observed rising edge, where the data path samples, and each observed falling edge, where the data path changes data. A stop request lets the current high phase finish and then parks the generator with the line released.

The controller has four states:
- `ST_IDLE`: the line is released and the counter is clear.
- `ST_LOW`: the block pulls the line low and counts the low phase.
- `ST_WAIT_HIGH`: the line is released and the block waits for the synchronised level to read high.
- `ST_HIGH`: the line is released and the block counts the high phase.

Transitions:
- `ST_IDLE`→`ST_LOW` when the block is enabled and no stop is requested.
- `ST_LOW`→`ST_WAIT_HIGH` when the low count expires.
- `ST_WAIT_HIGH`→`ST_HIGH` when the synchronised level reads high.
- `ST_HIGH`→`ST_LOW` when the line is seen low early, or when the high count expires with no stop request.
- `ST_HIGH`→`ST_IDLE` when the high count expires while a stop is requested.
- Any state→`ST_IDLE` when enable is low.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is active or enable is low, the controller is in `ST_IDLE`, `scl_pull_low` is 0 and the phase counter is clear. Enable going low in any state returns the controller to `ST_IDLE` at the next clock edge.
- R2: With `fast_mode`=0 and no other device on the line, `scl_pull_low` is 1 for exactly `STD_LOW_CYC` cycles per bit. The high count then lasts `STD_HIGH_CYC` cycles, starting from the first cycle the synchronised level reads high.
- R3: With `fast_mode`=1, the low phase lasts `FAST_LOW_CYC` cycles and the high count lasts `FAST_HIGH_CYC` cycles. The limit is chosen by the `fast_mode` value present in each cycle.
- R4: `scl_in` passes through two flops before any decision or edge detection. `scl_rise_stb` (or `scl_fall_stb`) is 1 for exactly one cycle, two clock edges after the edge at which a high (or low) level is first sampled following the opposite level.
- R5: After the low count expires, the block releases the line. The high count does not start while the synchronised level reads low, so a stretched clock lengthens the low phase and keeps the high phase at its full count.
- R6: If the synchronised level reads low during `ST_HIGH`, the next state is `ST_LOW` with the counter at zero, and the block pulls the line low for a full low count.
- R7: While `stop_req` is 1, the controller stays in `ST_IDLE`. If the high count expires while `stop_req` is 1, the controller enters `ST_IDLE` and leaves the line released instead of starting another low phase.
- R8: The block never drives the line high. `scl_pull_low` is 1 only in `ST_LOW`, and the outputs are a pull-low enable and two strobes only.
- R9: Both strobes are 0 whenever enable is low, even if the line toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low forces idle with the line released |
| fast_mode | input | 1 | 0 selects standard-mode counts, 1 selects fast-mode counts |
| stop_req | input | 1 | Finish the current high phase and then stay idle |
| scl_in | input | 1 | Sampled level of the open-drain clock line |
| scl_pull_low | output | 1 | 1 enables the pull-down on the clock line |
| scl_rise_stb | output | 1 | One-cycle strobe on an observed rising edge |
| scl_fall_stb | output | 1 | One-cycle strobe on an observed falling edge |

## Verification
The hardest situation to reach from the ports is a foreign device pulling the line low partway through the local high count. The stimulus has to land inside a high phase that is only a few cycles long and that starts three cycles after the release.

The bench reaches it by following its own reference model. It waits until the model is in the high phase with a known count, and only then asserts the external pull. It holds that pull longer than the local low count, so the same run also exercises a longer foreign low phase.

Clock stretching is produced the same way. The bench asserts the external pull on the exact cycle the model enters the wait state.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOW       = 2'd1,
        ST_WAIT_HIGH = 2'd2,
        ST_HIGH      = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_line_sync.sv
// Two-flop synchroniser on the clock line plus a third flop for edge detection.
module scl_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            last_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~last_q;
    assign fall  = ~sync_q & last_q;

endmodule

// File: rtl/scl_phase_timer.sv
// Shared phase counter: cleared on request, counts while running.
module scl_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          done
);

    logic [CW:0] next_val;

    assign next_val = {1'b0, count} + {{CW{1'b0}}, 1'b1};
    assign done     = run && (next_val >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run) begin
            count <= next_val[CW-1:0];
        end
    end

endmodule

// File: rtl/scl_clock_gen.sv
// Serial clock generator that follows the wired-AND clock line.
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int STD_LOW_CYC   = 250,
    parameter int STD_HIGH_CYC  = 250,
    parameter int FAST_LOW_CYC  = 65,
    parameter int FAST_HIGH_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fast_mode,
    input  logic stop_req,
    input  logic scl_in,
    output logic scl_pull_low,
    output logic scl_rise_stb,
    output logic scl_fall_stb
);

    localparam int STD_MAX  = (STD_LOW_CYC > STD_HIGH_CYC) ? STD_LOW_CYC : STD_HIGH_CYC;
    localparam int FAST_MAX = (FAST_LOW_CYC > FAST_HIGH_CYC) ? FAST_LOW_CYC : FAST_HIGH_CYC;
    localparam int MAX_CYC  = (STD_MAX > FAST_MAX) ? STD_MAX : FAST_MAX;
    localparam int CW       = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] LIM_STD_LOW   = CW'(STD_LOW_CYC);
    localparam logic [CW-1:0] LIM_STD_HIGH  = CW'(STD_HIGH_CYC);
    localparam logic [CW-1:0] LIM_FAST_LOW  = CW'(FAST_LOW_CYC);
    localparam logic [CW-1:0] LIM_FAST_HIGH = CW'(FAST_HIGH_CYC);

    scl_state_e    state;
    scl_state_e    state_nxt;
    logic          scl_level;
    logic          edge_rise;
    logic          edge_fall;
    logic [CW-1:0] phase_cnt;
    logic [CW-1:0] phase_lim;
    logic          phase_done;
    logic          cnt_clear;
    logic          cnt_run;

    scl_line_sync i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (scl_in),
        .level   (scl_level),
        .rise    (edge_rise),
        .fall    (edge_fall)
    );

    always_comb begin
        if (state == ST_HIGH) begin
            phase_lim = fast_mode ? LIM_FAST_HIGH : LIM_STD_HIGH;
        end else begin
            phase_lim = fast_mode ? LIM_FAST_LOW : LIM_STD_LOW;
        end
    end

    assign cnt_run   = (state == ST_LOW) || (state == ST_HIGH);
    assign cnt_clear = (state_nxt != state) || !cnt_run;

    scl_phase_timer #(
        .CW (CW)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .run   (cnt_run),
        .limit (phase_lim),
        .count (phase_cnt),
        .done  (phase_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (!enable) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!stop_req) state_nxt = ST_LOW;
                end
                ST_LOW: begin
                    if (phase_done) state_nxt = ST_WAIT_HIGH;
                end
                ST_WAIT_HIGH: begin
                    if (scl_level) state_nxt = ST_HIGH;
                end
                ST_HIGH: begin
                    if (!scl_level) begin
                        state_nxt = ST_LOW;
                    end else if (phase_done) begin
                        state_nxt = stop_req ? ST_IDLE : ST_LOW;
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        scl_pull_low = (state == ST_LOW);
        scl_rise_stb = enable & edge_rise;
        scl_fall_stb = enable & edge_fall;
    end

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk
    import scl_gen_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          stop_req,
    input logic          scl_in,
    input logic          scl_pull_low,
    input logic          scl_rise_stb,
    input scl_state_e    state,
    input logic [CW-1:0] phase_cnt,
    input logic          scl_level,
    input logic          phase_done
);

    AST_RELEASE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_pull_low); // R1

    AST_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_LOW && !phase_done) |=> scl_pull_low); // R2

    AST_RISE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_stb |-> ($past(scl_in, 2) && !$past(scl_in, 3))); // R4

    AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_WAIT_HIGH && !scl_level) |=> (!scl_pull_low && state == ST_WAIT_HIGH)); // R5

    AST_EARLY_LOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_HIGH && !scl_level) |=> (state == ST_LOW && phase_cnt == '0)); // R6

    AST_STOP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_HIGH && scl_level && phase_done && stop_req) |=> (state == ST_IDLE)); // R7

endmodule

bind scl_clock_gen scl_clock_gen_chk #(.CW(CW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .stop_req     (stop_req),
    .scl_in       (scl_in),
    .scl_pull_low (scl_pull_low),
    .scl_rise_stb (scl_rise_stb),
    .state        (state),
    .phase_cnt    (phase_cnt),
    .scl_level    (scl_level),
    .phase_done   (phase_done)
);

// File: tb/test_scl_clock_gen.sv
`timescale 1ns/1ps
module test_scl_clock_gen;

    localparam int SL = 12;
    localparam int SH = 10;
    localparam int FL = 5;
    localparam int FH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic fast_mode = 1'b0;
    logic stop_req = 1'b0;
    logic ext_pull = 1'b0;
    logic scl_in;
    logic scl_pull_low;
    logic scl_rise_stb;
    logic scl_fall_stb;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    assign scl_in = ~(scl_pull_low | ext_pull);

    scl_clock_gen #(
        .STD_LOW_CYC   (SL),
        .STD_HIGH_CYC  (SH),
        .FAST_LOW_CYC  (FL),
        .FAST_HIGH_CYC (FH)
    ) i_scl_clock_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .fast_mode    (fast_mode),
        .stop_req     (stop_req),
        .scl_in       (scl_in),
        .scl_pull_low (scl_pull_low),
        .scl_rise_stb (scl_rise_stb),
        .scl_fall_stb (scl_fall_stb)
    );

    // Behavioural reference: 0 parked, 1 pulling, 2 waiting for line, 3 timing high
    int m_phase = 0;
    int m_count = 0;
    bit m_hist[$] = '{1'b1, 1'b1, 1'b1};

    always @(posedge clk) begin
        bit line_now;
        bit seen;
        int lo;
        int hi;
        line_now = !(m_phase == 1) && !ext_pull;
        lo = fast_mode ? FL : SL;
        hi = fast_mode ? FH : SH;
        if (!rst_n) begin
            m_phase = 0;
            m_count = 0;
            m_hist = '{1'b1, 1'b1, 1'b1};
        end else begin
            seen = m_hist[1];
            m_hist.push_front(line_now);
            void'(m_hist.pop_back());
            if (!enable) begin
                m_phase = 0;
                m_count = 0;
            end else begin
                case (m_phase)
                    0: if (!stop_req) begin m_phase = 1; m_count = 0; end
                    1: begin
                        if (m_count + 1 >= lo) begin m_phase = 2; m_count = 0; end
                        else m_count++;
                    end
                    2: if (seen) begin m_phase = 3; m_count = 0; end
                    default: begin
                        if (!seen) begin m_phase = 1; m_count = 0; end
                        else if (m_count + 1 >= hi) begin
                            m_phase = stop_req ? 0 : 1;
                            m_count = 0;
                        end else m_count++;
                    end
                endcase
            end
        end
    end

    // Compare every cycle, midway between edges
    always @(posedge clk) begin
        bit e_pull;
        bit e_rise;
        bit e_fall;
        #5;
        e_pull = (m_phase == 1);
        e_rise = enable && m_hist[1] && !m_hist[2];
        e_fall = enable && !m_hist[1] && m_hist[2];
        vectors++;
        if (scl_pull_low !== e_pull || scl_rise_stb !== e_rise || scl_fall_stb !== e_fall) begin
            miscompares++;
            $display("FAIL %s t=%0t actual pull/rise/fall=%b%b%b expected=%b%b%b",
                     cur_req, $time, scl_pull_low, scl_rise_stb, scl_fall_stb,
                     e_pull, e_rise, e_fall);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            miscompares++;
            $display("FAIL watchdog t=%0t actual=hung expected=done", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_phase(input int ph);
        while (m_phase != ph) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(5);
        rst_n = 1'b1;
        run(5);

        // R2 / R8: standard mode free running
        cur_req = "R2";
        enable = 1'b1;
        run(100);

        // R5: slave stretches the clock after local release
        cur_req = "R5";
        wait_phase(2);
        ext_pull = 1'b1;
        run(15);
        ext_pull = 1'b0;
        run(40);

        // R6: another master pulls low early in the high phase and holds it long
        cur_req = "R6";
        wait_phase(3);
        run(3);
        ext_pull = 1'b1;
        run(20);
        ext_pull = 1'b0;
        run(40);
        wait_phase(3);
        run(1);
        ext_pull = 1'b1;
        run(4);
        ext_pull = 1'b0;
        run(30);

        // R3: fast mode, including a switch partway through a phase
        cur_req = "R3";
        fast_mode = 1'b1;
        run(60);
        wait_phase(1);
        run(8);
        fast_mode = 1'b0;
        run(2);
        fast_mode = 1'b1;
        run(40);

        // R7: stop request parks after the high phase
        cur_req = "R7";
        stop_req = 1'b1;
        run(40);
        stop_req = 1'b0;
        run(30);

        // R1: disable in the middle of a low phase
        cur_req = "R1";
        wait_phase(1);
        run(2);
        enable = 1'b0;
        run(10);

        // R9: line toggles while disabled give no strobes
        cur_req = "R9";
        for (int k = 0; k < 4; k++) begin
            ext_pull = 1'b1;
            run(6);
            ext_pull = 1'b0;
            run(6);
        end

        // R4: enabled but parked by stop, foreign edges give strobes
        cur_req = "R4";
        stop_req = 1'b1;
        enable = 1'b1;
        for (int k = 0; k < 4; k++) begin
            ext_pull = 1'b1;
            run(5 + k);
            ext_pull = 1'b0;
            run(5 + k);
        end
        ext_pull = 1'b1;
        run(1);
        ext_pull = 1'b0;
        run(8);
        stop_req = 1'b0;
        run(60);

        // R1: reset in the middle of operation
        cur_req = "R1";
        rst_n = 1'b0;
        run(4);
        rst_n = 1'b1;
        run(30);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule